// File: doc/BRIEF.md
# Symbol Timing Recovery Loop

This block takes a complex baseband stream at two samples per symbol and returns one symbol per symbol period. The symbols are taken at instants that a feedback loop keeps moving toward the best sampling point. The loop is built from four parts. A numerically controlled oscillator is a counter that counts down and wraps modulo one. Each time it wraps it marks a sample as a symbol strobe. A piecewise-parabolic interpolator evaluates the signal between samples at the fractional offset mu. Its coefficients are limited to 1, 1/2 and 3/2, so it needs only shifts and adds. A zero-crossing error detector and a proportional-plus-integral filter close the loop by changing the counter's step.

The rate is fixed, so the loop adjusts itself by stuffing or skipping. When the recovered delay crosses a whole symbol, the strobe pattern shows two ones or two zeros in a row, and one symbol more or one symbol fewer comes out than the nominal count. Input samples and output symbols both move on valid/ready handshakes.

Back-pressure works as follows. The output is a single register slot. `s_ready` is high when that slot is empty or is being emptied in the same cycle, so an input sample is accepted only when any symbol it produces has a place to go. While `m_valid` is high and `m_ready` is low, the symbol, `m_mu` and `strobe` hold, and no input is taken. `kp` and `ki` are static configuration and should only change while reset is asserted.

Top module: `sym_timing_loop`

## Requirements
- R1: Synchronous active-high reset sets the counter to 1.0 (65536) and clears the integrator, loop output, delay line, previous symbol and output slot. Afterwards `m_valid`=0, `strobe`=0 and `s_ready`=1. The first three accepted samples never raise a strobe, although the counter still runs and wraps for them.
- R2: For each accepted sample the counter computes next = eta - (32768 + v), where v is the signed 16-bit loop output. A negative result is an underflow: eta becomes next + 65536 and the sample is a strobe. Otherwise eta becomes next. With zero gains the strobe reads 0,0,0,0,1,0,1,... from reset.
- R3: On a strobe, mu = min(2*eta, 65535), using eta as it was before that sample. mu goes out with the symbol as `m_mu`.
- R4: Let x0 be the new sample and x1..x3 the three before it. With a2 = x0-x1-x2+x3 and a1 = 3*x1-x0-x2-x3, the symbol is sat16(x2 + (((a1 + ((a2*mu)>>>16)) * mu) >>> 17)). The shifts are arithmetic, so values round toward minus infinity. I and Q are handled alike.
- R5: The mid interpolant uses the same formula and mu on the window moved one sample older. For each rail, d = 0 when the previous and current symbols share a sign, and d = +1 when the previous symbol is non-negative and the current one is negative. Otherwise d = -1. Zero counts as non-negative. The error is e = sat16(mid_I*d_I + mid_Q*d_Q).
- R6: Only on a strobe: integ = sat16(integ + ((e*ki)>>>16)) and v = sat16(((e*kp)>>>16) + integ), with `kp` and `ki` unsigned. The counter uses the new v starting with the next sample.
- R7: A sustained positive error produces two strobes in a row (a stuffed symbol). A sustained negative error produces two non-strobe samples in a row after the first strobe (a skipped symbol).
- R8: While `m_valid` && !`m_ready`, `s_ready` is 0 and the symbol and mu hold. Every strobe delivers exactly one symbol, in order, with none lost or repeated.
- R9: `strobe` shows the strobe decision for the most recently accepted sample and does not change in cycles where no sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high with s_valid |
| s_i | input | 16 | In-phase sample, signed Q1.15 |
| s_q | input | 16 | Quadrature sample, signed Q1.15 |
| kp | input | 16 | Proportional gain, unsigned fraction |
| ki | input | 16 | Integral gain, unsigned fraction |
| m_valid | output | 1 | Output symbol valid |
| m_ready | input | 1 | Downstream accepts the symbol |
| m_i | output | 16 | Interpolated in-phase symbol |
| m_q | output | 16 | Interpolated quadrature symbol |
| m_mu | output | 16 | Fractional interval of the symbol, unsigned |
| strobe | output | 1 | Strobe decision of the last accepted sample |

## Verification
A wrong counter value or an off-by-one step first shows up as a change in the strobe pattern. This appears on the very sample it happens, since `strobe` is updated by every accepted sample, and it also shows in `m_mu` on the next symbol. A fault in the error detector or loop filter produces no visible output until the following strobe. It then appears in both mu and the strobe rhythm, and it carries forward into every later symbol, so a sample-by-sample arithmetic model catches it within two symbols. Wrong delay-line alignment changes the symbol values at once, even with zero gain and mu at zero.

// File: rtl/stl_pkg.sv
package stl_pkg;
  localparam int SAMPLE_W       = 16;
  localparam int FRAC_W         = 16;
  localparam int GAIN_W         = 16;
  localparam int WARMUP_SAMPLES = 3;

  // half of sgn(prev) - sgn(cur); zero counts as non-negative
  function automatic logic signed [1:0] zc_dir(input logic prev_neg, input logic cur_neg);
    if (prev_neg == cur_neg) return 2'sd0;
    else if (cur_neg)        return 2'sd1;
    else                     return -2'sd1;
  endfunction
endpackage

// File: rtl/stl_farrow.sv
module stl_farrow #(
  parameter int DW  = 16,
  parameter int MUW = 16
) (
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] x2,
  input  logic signed [DW-1:0] x3,
  input  logic        [MUW-1:0] mu,
  output logic signed [DW-1:0] y
);
  localparam int AW = DW + MUW + 8;
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (DW-1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - 1;

  logic signed [AW-1:0] e0, e1, e2, e3, muw, a2, a1, t, s, acc;

  always_comb begin
    e0  = AW'(x0);
    e1  = AW'(x1);
    e2  = AW'(x2);
    e3  = AW'(x3);
    muw = AW'({1'b0, mu});
    // doubled parabola coefficients: only +-1/2 and 3/2 scaled by two
    a2  = e0 - e1 - e2 + e3;
    a1  = (e1 <<< 1) + e1 - e0 - e2 - e3;
    t   = (a2 * muw) >>> MUW;
    s   = a1 + t;
    acc = e2 + ((s * muw) >>> (MUW + 1));
    if (acc > MAXV)      y = MAXV[DW-1:0];
    else if (acc < MINV) y = MINV[DW-1:0];
    else                 y = acc[DW-1:0];
  end
endmodule

// File: rtl/stl_zcted.sv
module stl_zcted import stl_pkg::*; #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] prev_i,
  input  logic signed [DW-1:0] prev_q,
  input  logic signed [DW-1:0] mid_i,
  input  logic signed [DW-1:0] mid_q,
  input  logic signed [DW-1:0] cur_i,
  input  logic signed [DW-1:0] cur_q,
  output logic signed [DW-1:0] err
);
  localparam int EW = DW + 2;
  localparam logic signed [EW-1:0] EMAX = EW'((1 << (DW-1)) - 1);
  localparam logic signed [EW-1:0] EMIN = -EMAX - 1;

  logic signed [1:0]    di, dq;
  logic signed [EW-1:0] ti, tq, sum;

  always_comb begin
    di  = zc_dir(prev_i[DW-1], cur_i[DW-1]);
    dq  = zc_dir(prev_q[DW-1], cur_q[DW-1]);
    ti  = (di == 2'sd0) ? '0 : (di == 2'sd1) ? EW'(mid_i) : -EW'(mid_i);
    tq  = (dq == 2'sd0) ? '0 : (dq == 2'sd1) ? EW'(mid_q) : -EW'(mid_q);
    sum = ti + tq;
    if (sum > EMAX)      err = EMAX[DW-1:0];
    else if (sum < EMIN) err = EMIN[DW-1:0];
    else                 err = sum[DW-1:0];
  end
endmodule

// File: rtl/stl_loopfilt.sv
module stl_loopfilt #(
  parameter int DW = 16,
  parameter int GW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] err,
  input  logic        [GW-1:0] kp,
  input  logic        [GW-1:0] ki,
  output logic signed [DW-1:0] v
);
  localparam int LW = DW + GW + 2;
  localparam logic signed [LW-1:0] LMAX = LW'((1 << (DW-1)) - 1);
  localparam logic signed [LW-1:0] LMIN = -LMAX - 1;

  function automatic logic signed [DW-1:0] clip(input logic signed [LW-1:0] a);
    if (a > LMAX)      return LMAX[DW-1:0];
    else if (a < LMIN) return LMIN[DW-1:0];
    else               return a[DW-1:0];
  endfunction

  logic signed [DW-1:0] integ, integ_nx, v_nx;
  logic signed [LW-1:0] ew, kpw, kiw, prop, iadd;

  always_comb begin
    ew       = LW'(err);
    kpw      = LW'({1'b0, kp});
    kiw      = LW'({1'b0, ki});
    prop     = (ew * kpw) >>> GW;
    iadd     = (ew * kiw) >>> GW;
    integ_nx = clip(LW'(integ) + iadd);
    v_nx     = clip(prop + LW'(integ_nx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ <= '0;
      v     <= '0;
    end else if (en) begin
      integ <= integ_nx;
      v     <= v_nx;
    end
  end
endmodule

// File: rtl/sym_timing_loop.sv
module sym_timing_loop import stl_pkg::*; #(
  parameter int DW     = SAMPLE_W,
  parameter int MUW    = FRAC_W,
  parameter int GW     = GAIN_W,
  parameter int WARMUP = WARMUP_SAMPLES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [DW-1:0] s_q,
  input  logic        [GW-1:0] kp,
  input  logic        [GW-1:0] ki,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [DW-1:0] m_i,
  output logic signed [DW-1:0] m_q,
  output logic        [MUW-1:0] m_mu,
  output logic                 strobe
);
  localparam int ETW   = MUW + 2;
  localparam int CW    = $clog2(WARMUP + 1);
  localparam int LANES = 2;
  localparam int TAPS  = 4;
  localparam logic signed [ETW-1:0] ETA_ONE  = ETW'(1 << MUW);
  localparam logic signed [ETW-1:0] ETA_HALF = ETW'(1 << (MUW - 1));

  logic signed [DW-1:0]  dly    [LANES][TAPS];
  logic signed [DW-1:0]  smp    [LANES];
  logic signed [DW-1:0]  y_cur  [LANES];
  logic signed [DW-1:0]  y_mid  [LANES];
  logic signed [DW-1:0]  y_prev [LANES];
  logic signed [ETW-1:0] eta, step, nxt;
  logic        [ETW:0]   dbl;
  logic        [MUW-1:0] mu_now;
  logic        [CW-1:0]  warm;
  logic signed [DW-1:0]  err, v;
  logic                  take, under, warm_done, fire;

  assign smp[0] = s_i;
  assign smp[1] = s_q;

  assign s_ready   = !m_valid || m_ready;
  assign take      = s_valid && s_ready;
  assign warm_done = (warm == CW'(WARMUP));

  // decrementing modulo-1 counter with nominal step of one half
  always_comb begin
    step   = ETA_HALF + ETW'(v);
    nxt    = eta - step;
    under  = nxt[ETW-1];
    dbl    = {eta, 1'b0};
    mu_now = (|dbl[ETW:MUW]) ? '1 : dbl[MUW-1:0];
    fire   = take && under && warm_done;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    stl_farrow #(.DW(DW), .MUW(MUW)) u_cur (
      .x0(smp[l]), .x1(dly[l][0]), .x2(dly[l][1]), .x3(dly[l][2]),
      .mu(mu_now), .y(y_cur[l])
    );
    stl_farrow #(.DW(DW), .MUW(MUW)) u_mid (
      .x0(dly[l][0]), .x1(dly[l][1]), .x2(dly[l][2]), .x3(dly[l][3]),
      .mu(mu_now), .y(y_mid[l])
    );
  end

  stl_zcted #(.DW(DW)) u_ted (
    .prev_i(y_prev[0]), .prev_q(y_prev[1]),
    .mid_i (y_mid[0]),  .mid_q (y_mid[1]),
    .cur_i (y_cur[0]),  .cur_q (y_cur[1]),
    .err   (err)
  );

  stl_loopfilt #(.DW(DW), .GW(GW)) u_lf (
    .clk(clk), .rst(rst), .en(fire), .err(err), .kp(kp), .ki(ki), .v(v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eta     <= ETA_ONE;
      warm    <= '0;
      strobe  <= 1'b0;
      m_valid <= 1'b0;
      m_i     <= '0;
      m_q     <= '0;
      m_mu    <= '0;
      for (int l = 0; l < LANES; l++) begin
        y_prev[l] <= '0;
        for (int k = 0; k < TAPS; k++) dly[l][k] <= '0;
      end
    end else begin
      if (take) begin
        for (int l = 0; l < LANES; l++) begin
          for (int k = TAPS - 1; k > 0; k--) dly[l][k] <= dly[l][k-1];
          dly[l][0] <= smp[l];
        end
        eta    <= under ? nxt + ETA_ONE : nxt;
        strobe <= fire;
        if (!warm_done) warm <= warm + CW'(1);
        if (fire) begin
          for (int l = 0; l < LANES; l++) y_prev[l] <= y_cur[l];
          m_i  <= y_cur[0];
          m_q  <= y_cur[1];
          m_mu <= mu_now;
        end
      end
      if (fire)         m_valid <= 1'b1;
      else if (m_ready) m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stl_checker.sv
module stl_checker #(
  parameter int DW     = 16,
  parameter int MUW    = 16,
  parameter int WARMUP = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic signed [DW-1:0] m_i,
  input logic signed [DW-1:0] m_q,
  input logic        [MUW-1:0] m_mu,
  input logic                 strobe
);
  logic [7:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (s_valid && s_ready && seen != 8'hFF) seen <= seen + 8'd1;
  end

  // R1: no strobe during the warm-up samples
  a_r1_warmup: assert property (@(posedge clk) disable iff (rst)
    (seen <= 8'(WARMUP)) |-> !strobe);

  // R2: a fresh symbol only appears together with a strobe
  a_r2_newsym: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> strobe);

  // R8: a stalled symbol holds its value
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q) && $stable(m_mu)));

  // R8: a full, stalled slot refuses input
  a_r8_full: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  // R9: strobe changes only with an accepted sample
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> $stable(strobe));
endmodule

bind sym_timing_loop stl_checker #(.DW(DW), .MUW(MUW), .WARMUP(WARMUP)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q),
  .m_mu(m_mu), .strobe(strobe)
);

// File: tb/sym_timing_loop_tb.sv
`timescale 1ns/1ps
module sym_timing_loop_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic s_valid = 1'b0, m_ready = 1'b0;
  logic signed [15:0] s_i = '0, s_q = '0;
  logic [15:0] kp = '0, ki = '0;
  logic s_ready, m_valid, strobe;
  logic signed [15:0] m_i, m_q;
  logic [15:0] m_mu;

  int n_chk = 0, n_err = 0, cyc = 0;

  // bench model state
  longint meta, minteg, mv, mpi, mpq;
  longint mdi [4];
  longint mdq [4];
  int mcnt;
  int qi[$], qq[$], qmu[$];
  bit prev_stb, any_fire;
  int ones_pair, zeros_pair;

  sym_timing_loop u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .kp(kp), .ki(ki),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q),
    .m_mu(m_mu), .strobe(strobe)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic longint sat16(input longint a);
    if (a > 32767) return 32767;
    if (a < -32768) return -32768;
    return a;
  endfunction

  function automatic longint interp(input longint x0, x1, x2, x3, mu);
    longint a2, a1, t, s;
    a2 = x0 - x1 - x2 + x3;
    a1 = 3*x1 - x0 - x2 - x3;
    t  = (a2 * mu) >>> 16;
    s  = a1 + t;
    return sat16(x2 + ((s * mu) >>> 17));
  endfunction

  function automatic longint dirv(input longint p, input longint c);
    if ((p < 0) == (c < 0)) return 0;
    return (c < 0) ? 1 : -1;
  endfunction

  task automatic check(input string req, input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input longint si, input longint sq, output bit stb);
    longint stp, nxt, mu, yi, yq, hi, hq, e;
    bit under, fire;
    stp   = 32768 + mv;
    nxt   = meta - stp;
    under = (nxt < 0);
    mu    = meta * 2;
    if (mu > 65535) mu = 65535;
    fire  = under && (mcnt >= 3);
    if (fire) begin
      yi = interp(si, mdi[0], mdi[1], mdi[2], mu);
      yq = interp(sq, mdq[0], mdq[1], mdq[2], mu);
      hi = interp(mdi[0], mdi[1], mdi[2], mdi[3], mu);
      hq = interp(mdq[0], mdq[1], mdq[2], mdq[3], mu);
      e  = sat16(hi * dirv(mpi, yi) + hq * dirv(mpq, yq));
      minteg = sat16(minteg + ((e * longint'(ki)) >>> 16));
      mv     = sat16(((e * longint'(kp)) >>> 16) + minteg);
      mpi = yi; mpq = yq;
      qi.push_back(int'(yi)); qq.push_back(int'(yq)); qmu.push_back(int'(mu));
    end
    meta = under ? nxt + 65536 : nxt;
    if (mcnt < 3) mcnt++;
    for (int k = 3; k > 0; k--) begin mdi[k] = mdi[k-1]; mdq[k] = mdq[k-1]; end
    mdi[0] = si; mdq[0] = sq;
    stb = fire;
  endtask

  task automatic take_out();
    int ei, eq, emu;
    if (qi.size() == 0) check("R8", 1, 0, "unexpected extra symbol");
    else begin
      ei = qi.pop_front(); eq = qq.pop_front(); emu = qmu.pop_front();
      check("R4", m_i, ei, "symbol I");
      check("R4", m_q, eq, "symbol Q");
      check("R3", m_mu, emu, "mu");
    end
  endtask

  task automatic do_reset(input logic [15:0] g_p, input logic [15:0] g_i);
    rst = 1'b1; s_valid = 1'b0; m_ready = 1'b0; kp = g_p; ki = g_i;
    repeat (3) @(negedge clk);
    check("R1", m_valid, 0, "m_valid in reset");
    check("R1", strobe, 0, "strobe in reset");
    check("R1", s_ready, 1, "s_ready in reset");
    rst = 1'b0;
    meta = 65536; minteg = 0; mv = 0; mpi = 0; mpq = 0; mcnt = 0;
    for (int k = 0; k < 4; k++) begin mdi[k] = 0; mdq[k] = 0; end
    qi.delete(); qq.delete(); qmu.delete();
    prev_stb = 0; any_fire = 0; ones_pair = 0; zeros_pair = 0;
    @(negedge clk);
  endtask

  task automatic push(input int si, input int sq, input bit rdy, input string req);
    bit acc, stb;
    s_valid = 1'b1; s_i = 16'(si); s_q = 16'(sq); m_ready = rdy;
    forever begin
      #1;
      if (m_valid && m_ready) take_out();
      acc = s_ready;
      @(negedge clk);
      if (acc) break;
      m_ready = 1'b1;
    end
    s_valid = 1'b0; m_ready = 1'b0;
    model_step(si, sq, stb);
    check(req, strobe, stb, "strobe");
    if (any_fire) begin
      if (strobe && prev_stb) ones_pair++;
      if (!strobe && !prev_stb) zeros_pair++;
    end
    if (strobe) any_fire = 1;
    prev_stb = strobe;
  endtask

  task automatic stall();
    logic signed [15:0] hi, hq;
    logic [15:0] hm;
    logic hs;
    hi = m_i; hq = m_q; hm = m_mu; hs = strobe;
    s_valid = 1'b1; s_i = 16'sh1234; m_ready = 1'b0;
    repeat (6) begin
      #1;
      check("R8", s_ready, 0, "s_ready while full and stalled");
      @(negedge clk);
      check("R8", m_valid, 1, "m_valid held");
      check("R8", m_i, hi, "I held");
      check("R8", m_q, hq, "Q held");
      check("R8", m_mu, hm, "mu held");
      check("R9", strobe, hs, "strobe without accept");
    end
    s_valid = 1'b0;
  endtask

  task automatic drain();
    s_valid = 1'b0; m_ready = 1'b1;
    repeat (3) begin
      #1;
      if (m_valid) take_out();
      @(negedge clk);
    end
    m_ready = 1'b0;
    check("R8", qi.size(), 0, "symbols not delivered");
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  initial begin
    // zero gain: warm-up, fixed rhythm, mu zero, pure delay
    do_reset(16'h0000, 16'h0000);
    for (int n = 0; n < 80; n++) push(rnd16(), rnd16(), 1'b1, (n < 3) ? "R1" : "R2");
    drain();

    // PI gains, random data, random back-pressure with stalls
    do_reset(16'h2000, 16'h0400);
    for (int n = 0; n < 600; n++) begin
      push(rnd16() / 2, rnd16() / 2, 1'($urandom_range(1)), "R5");
      if (n % 37 == 0 && m_valid) stall();
    end
    drain();

    // stronger gains, near-sinusoidal data with noise
    do_reset(16'h4000, 16'h0100);
    for (int n = 0; n < 600; n++) begin
      int base;
      base = (n % 4 == 0) ? 20000 : (n % 4 == 2) ? -20000 : ((n % 4 == 1) ? 9000 : -9000);
      push(base + int'($urandom_range(4000)) - 2000, int'($urandom_range(8000)) - 4000,
           1'($urandom_range(1)), "R6");
    end
    drain();

    // full-scale swing to reach saturation in interpolation
    do_reset(16'h7000, 16'h2000);
    for (int n = 0; n < 300; n++)
      push((n % 2 == 0) ? 32767 : -32768, (n % 3 == 0) ? -32768 : 32767, 1'b1, "R4");
    drain();

    // positive error drive: a stuffed strobe must appear
    do_reset(16'h0000, 16'hFFFF);
    for (int n = 0; n < 40; n++) begin
      int pv;
      pv = (n % 4 == 0) ? 12288 : (n % 4 == 1) ? 16384 : (n % 4 == 2) ? -12288 : -16384;
      push(pv, 0, 1'b1, "R7");
    end
    check("R7", (ones_pair > 0) ? 1 : 0, 1, "two strobes in a row seen");
    drain();

    // negative error drive: a skipped strobe must appear
    do_reset(16'h0000, 16'hFFFF);
    for (int n = 0; n < 40; n++) begin
      int pv;
      pv = (n % 4 == 0) ? 12288 : (n % 4 == 1) ? -16384 : (n % 4 == 2) ? -12288 : 16384;
      push(pv, 0, 1'b1, "R7");
    end
    check("R7", (zeros_pair > 0) ? 1 : 0, 1, "two non-strobes in a row seen");
    drain();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule